// File: doc/BRIEF.md
# Exception Prioritizer and State Capture

This unit sits at the retirement point of a 32-bit in-order pipeline. In each cycle the retiring instruction may raise any mix of five exception requests: a bus error on its instruction fetch, a bus error on its data access, a system-call trap, a software debug breakpoint, and a translation-invalid fault. The unit picks one winner by a fixed ranking and issues a one-cycle redirect carrying the new fetch address. A debug breakpoint goes to a dedicated debug vector. Every other source goes to the general vector, which sits 0x180 above a configurable exception base.

The unit keeps the architectural control state that the exception handler reads. For normal exceptions this is the cause code, the branch-delay flag, the imprecise-error flag and the exception return PC. For a translation-invalid fault it also keeps the bad virtual address, the page-number fields of the context and entry-high views, and the address-space tag. For a debug breakpoint it keeps the breakpoint and delay-slot status bits and the debug return PC. All of this state updates on the same clock edge that raises the redirect.

Top module: `exc_prio_capture`

## Requirements
- R1: `redirect_valid` is high for exactly the one cycle after each edge where `req_valid` is high and at least one request bit is set. At all other times it is low. Request bits are ignored while `req_valid` is low.
- R2: A winning fetch bus error, data bus error, system call or translation fault sets `redirect_pc` to EXC_BASE + 0x180. `redirect_pc` holds its value between redirects.
- R3: When requests coincide, the fixed ranking from highest to lowest is: debug breakpoint, fetch bus error, translation fault, data bus error, system call. In particular, a fetch bus error always beats a data bus error.
- R4: A normal exception writes the 5-bit `cause_code` as follows: fetch bus error 6, data bus error 7, system call 8, translation-invalid fault 2.
- R5: A normal exception sets `epc` to `inst_pc`. When `in_delay_slot` is high, it instead sets `epc` to `branch_pc` and sets `cause_bd` high. Otherwise `cause_bd` is low.
- R6: A winning translation fault copies `fault_vaddr` into `badvaddr`. It copies `fault_vaddr[31:13]` into both `ctx_vpn` and `ehi_vpn`, and copies `fault_asid` into `ehi_asid`.
- R7: Bus errors and system calls leave `badvaddr`, `ctx_vpn`, `ehi_vpn` and `ehi_asid` unchanged.
- R8: A winning debug breakpoint does the following: it sets `redirect_pc` to DBG_VECTOR and sets `dbg_bp` high; it sets `dbg_dd` to `in_delay_slot`; it sets `depc` to `inst_pc`, or to `branch_pc` when in a delay slot. It leaves `cause_code`, `cause_bd`, `cause_imprecise` and `epc` unchanged. Normal exceptions leave `dbg_bp`, `dbg_dd` and `depc` unchanged.
- R9: When a bus error wins, `cause_imprecise` takes the value of `err_imprecise`. When a system call or translation fault wins, it is cleared.
- R10: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A retiring instruction is presenting requests |
| req_ifetch_err | input | 1 | Bus error on instruction fetch |
| req_data_err | input | 1 | Bus error on data access |
| req_syscall | input | 1 | System-call trap |
| req_dbg_break | input | 1 | Software debug breakpoint |
| req_xlate_inv | input | 1 | Translation-invalid fault |
| err_imprecise | input | 1 | The bus error is imprecise |
| in_delay_slot | input | 1 | The instruction sits in a branch delay slot |
| inst_pc | input | 32 | PC of the retiring instruction |
| branch_pc | input | 32 | PC of the preceding branch |
| fault_vaddr | input | 32 | Faulting virtual address |
| fault_asid | input | 8 | Address-space tag of the faulting reference |
| redirect_valid | output | 1 | One-cycle redirect strobe |
| redirect_pc | output | 32 | Redirect target |
| cause_code | output | 5 | Exception cause code |
| cause_bd | output | 1 | Branch-delay flag |
| cause_imprecise | output | 1 | Imprecise bus-error flag |
| epc | output | 32 | Exception return PC |
| badvaddr | output | 32 | Bad virtual address |
| ctx_vpn | output | 19 | Context page-number field |
| ehi_vpn | output | 19 | Entry-high page-number field |
| ehi_asid | output | 8 | Entry-high address-space tag |
| dbg_bp | output | 1 | Debug breakpoint status bit |
| dbg_dd | output | 1 | Debug delay-slot status bit |
| depc | output | 32 | Debug return PC |

## Verification
The sources that can fall in the same cycle and need judging are the fetch bus error and the data bus error. The translation fault and the debug breakpoint also overlap the two bus errors. The bench raises these pairs, and all five requests at once, in a single retiring cycle. It then checks the cause code, the vector and the untouched register groups against a model that applies the ranking. Imprecise flags and delay-slot variants are overlaid on the colliding cycles, so a wrong winner would show up as a wrong cause code, a wrong return PC or a clobbered page field.

// File: rtl/exc_prio_pkg.sv
`timescale 1ns/1ps
package exc_prio_pkg;
    // Request indices; a lower index ranks higher.
    localparam int unsigned SRC_DEBUG   = 0;
    localparam int unsigned SRC_IFETCH  = 1;
    localparam int unsigned SRC_XLATE   = 2;
    localparam int unsigned SRC_DDATA   = 3;
    localparam int unsigned SRC_SYSCALL = 4;
    localparam int unsigned NUM_SRC     = 5;

    localparam int unsigned CODE_W = 5;
    localparam logic [CODE_W-1:0] CODE_XLATE   = 5'd2;
    localparam logic [CODE_W-1:0] CODE_IFETCH  = 5'd6;
    localparam logic [CODE_W-1:0] CODE_DDATA   = 5'd7;
    localparam logic [CODE_W-1:0] CODE_SYSCALL = 5'd8;

    localparam logic [31:0] GEN_VEC_OFFSET = 32'h0000_0180;
endpackage

// File: rtl/exc_arbiter.sv
`timescale 1ns/1ps
module exc_arbiter #(
    parameter int unsigned N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    logic [N:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_rank
        assign grant[i]     = req[i] & ~blocked[i];
        assign blocked[i+1] = blocked[i] | req[i];
    end

    assign any = blocked[N];

    always_comb begin
        a_r3_onehot_grant: assert ($onehot0(grant))
            else $error("R3 grant not one-hot");
    end
endmodule

// File: rtl/exc_capture.sv
`timescale 1ns/1ps
module exc_capture
    import exc_prio_pkg::*;
#(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned ASID_W     = 8,
    parameter int unsigned VPN_LO     = 13,
    parameter logic [XLEN-1:0] EXC_BASE   = 32'h8000_0000,
    parameter logic [XLEN-1:0] DBG_VECTOR = 32'hBFC0_0480
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    grant,
    input  logic                  err_imprecise,
    input  logic                  in_delay_slot,
    input  logic [XLEN-1:0]       inst_pc,
    input  logic [XLEN-1:0]       branch_pc,
    input  logic [XLEN-1:0]       fault_vaddr,
    input  logic [ASID_W-1:0]     fault_asid,
    output logic                  redirect_valid,
    output logic [XLEN-1:0]       redirect_pc,
    output logic [CODE_W-1:0]     cause_code,
    output logic                  cause_bd,
    output logic                  cause_imprecise,
    output logic [XLEN-1:0]       epc,
    output logic [XLEN-1:0]       badvaddr,
    output logic [XLEN-VPN_LO-1:0] ctx_vpn,
    output logic [XLEN-VPN_LO-1:0] ehi_vpn,
    output logic [ASID_W-1:0]     ehi_asid,
    output logic                  dbg_bp,
    output logic                  dbg_dd,
    output logic [XLEN-1:0]       depc
);
    localparam int unsigned VPN_W = XLEN - VPN_LO;
    localparam logic [XLEN-1:0] GEN_VECTOR = EXC_BASE + XLEN'(GEN_VEC_OFFSET);

    typedef struct packed {
        logic              redir_valid;
        logic [XLEN-1:0]   redir_pc;
        logic [CODE_W-1:0] code;
        logic              bd;
        logic              imprecise;
        logic [XLEN-1:0]   epc;
        logic [XLEN-1:0]   badva;
        logic [VPN_W-1:0]  ctx_vpn;
        logic [VPN_W-1:0]  ehi_vpn;
        logic [ASID_W-1:0] asid;
        logic              dbp;
        logic              ddd;
        logic [XLEN-1:0]   depc;
    } cap_state_t;

    cap_state_t state_d, state_q;
    logic [XLEN-1:0] ret_pc_d;

    always_comb begin
        state_d             = state_q;
        state_d.redir_valid = 1'b0;
        ret_pc_d            = in_delay_slot ? branch_pc : inst_pc;

        if (grant[SRC_DEBUG]) begin
            state_d.redir_valid = 1'b1;
            state_d.redir_pc    = DBG_VECTOR;
            state_d.dbp         = 1'b1;
            state_d.ddd         = in_delay_slot;
            state_d.depc        = ret_pc_d;
        end else if (|grant) begin
            state_d.redir_valid = 1'b1;
            state_d.redir_pc    = GEN_VECTOR;
            state_d.epc         = ret_pc_d;
            state_d.bd          = in_delay_slot;
            state_d.imprecise   = 1'b0;
            if (grant[SRC_IFETCH]) begin
                state_d.code      = CODE_IFETCH;
                state_d.imprecise = err_imprecise;
            end else if (grant[SRC_XLATE]) begin
                state_d.code    = CODE_XLATE;
                state_d.badva   = fault_vaddr;
                state_d.ctx_vpn = fault_vaddr[XLEN-1:VPN_LO];
                state_d.ehi_vpn = fault_vaddr[XLEN-1:VPN_LO];
                state_d.asid    = fault_asid;
            end else if (grant[SRC_DDATA]) begin
                state_d.code      = CODE_DDATA;
                state_d.imprecise = err_imprecise;
            end else begin
                state_d.code = CODE_SYSCALL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign redirect_valid  = state_q.redir_valid;
    assign redirect_pc     = state_q.redir_pc;
    assign cause_code      = state_q.code;
    assign cause_bd        = state_q.bd;
    assign cause_imprecise = state_q.imprecise;
    assign epc             = state_q.epc;
    assign badvaddr        = state_q.badva;
    assign ctx_vpn         = state_q.ctx_vpn;
    assign ehi_vpn         = state_q.ehi_vpn;
    assign ehi_asid        = state_q.asid;
    assign dbg_bp          = state_q.dbp;
    assign dbg_dd          = state_q.ddd;
    assign depc            = state_q.depc;

    // R7: a bus error or syscall win keeps the translation view intact
    a_r7_xlate_view_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[SRC_IFETCH] | grant[SRC_DDATA] | grant[SRC_SYSCALL])
        |=> ($stable(badvaddr) && $stable(ctx_vpn) && $stable(ehi_vpn) && $stable(ehi_asid)))
        else $error("R7 translation fields disturbed");

    // R8: debug entry leaves normal exception state alone
    a_r8_debug_keeps_cause: assert property (@(posedge clk) disable iff (!rst_n)
        grant[SRC_DEBUG] |=> ($stable(cause_code) && $stable(epc) && $stable(cause_bd) && dbg_bp))
        else $error("R8 debug entry disturbed cause state");
endmodule

// File: rtl/exc_prio_capture.sv
`timescale 1ns/1ps
module exc_prio_capture
    import exc_prio_pkg::*;
#(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned ASID_W     = 8,
    parameter int unsigned VPN_LO     = 13,
    parameter logic [XLEN-1:0] EXC_BASE   = 32'h8000_0000,
    parameter logic [XLEN-1:0] DBG_VECTOR = 32'hBFC0_0480
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_ifetch_err,
    input  logic                   req_data_err,
    input  logic                   req_syscall,
    input  logic                   req_dbg_break,
    input  logic                   req_xlate_inv,
    input  logic                   err_imprecise,
    input  logic                   in_delay_slot,
    input  logic [XLEN-1:0]        inst_pc,
    input  logic [XLEN-1:0]        branch_pc,
    input  logic [XLEN-1:0]        fault_vaddr,
    input  logic [ASID_W-1:0]      fault_asid,
    output logic                   redirect_valid,
    output logic [XLEN-1:0]        redirect_pc,
    output logic [CODE_W-1:0]      cause_code,
    output logic                   cause_bd,
    output logic                   cause_imprecise,
    output logic [XLEN-1:0]        epc,
    output logic [XLEN-1:0]        badvaddr,
    output logic [XLEN-VPN_LO-1:0] ctx_vpn,
    output logic [XLEN-VPN_LO-1:0] ehi_vpn,
    output logic [ASID_W-1:0]      ehi_asid,
    output logic                   dbg_bp,
    output logic                   dbg_dd,
    output logic [XLEN-1:0]        depc
);
    localparam logic [XLEN-1:0] GEN_VECTOR = EXC_BASE + XLEN'(GEN_VEC_OFFSET);

    logic [NUM_SRC-1:0] req_raw;
    logic [NUM_SRC-1:0] req_gated;
    logic [NUM_SRC-1:0] grant;
    logic               any_req;

    always_comb begin
        req_raw              = '0;
        req_raw[SRC_DEBUG]   = req_dbg_break;
        req_raw[SRC_IFETCH]  = req_ifetch_err;
        req_raw[SRC_XLATE]   = req_xlate_inv;
        req_raw[SRC_DDATA]   = req_data_err;
        req_raw[SRC_SYSCALL] = req_syscall;
        req_gated            = req_raw & {NUM_SRC{req_valid}};
    end

    exc_arbiter #(.N(NUM_SRC)) u_arb (
        .req   (req_gated),
        .grant (grant),
        .any   (any_req)
    );

    exc_capture #(
        .XLEN(XLEN), .ASID_W(ASID_W), .VPN_LO(VPN_LO),
        .EXC_BASE(EXC_BASE), .DBG_VECTOR(DBG_VECTOR)
    ) u_cap (
        .clk, .rst_n, .grant, .err_imprecise, .in_delay_slot,
        .inst_pc, .branch_pc, .fault_vaddr, .fault_asid,
        .redirect_valid, .redirect_pc, .cause_code, .cause_bd,
        .cause_imprecise, .epc, .badvaddr, .ctx_vpn, .ehi_vpn,
        .ehi_asid, .dbg_bp, .dbg_dd, .depc
    );

    // R1: a presented request always yields a redirect on the next cycle
    a_r1_redirect_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_ifetch_err || req_data_err || req_syscall || req_dbg_break || req_xlate_inv))
        |=> redirect_valid)
        else $error("R1 missing redirect");

    // R1: no request, no redirect
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && (req_ifetch_err || req_data_err || req_syscall || req_dbg_break || req_xlate_inv))
        |=> !redirect_valid)
        else $error("R1 spurious redirect");

    // R3: fetch bus error outranks data bus error
    a_r3_fetch_beats_data: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ifetch_err && req_data_err && !req_dbg_break)
        |=> (cause_code == CODE_IFETCH && redirect_pc == GEN_VECTOR))
        else $error("R3 data error won over fetch error");

    // R6: translation fault page fields mirror the bad address
    a_r6_page_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_xlate_inv && !req_dbg_break && !req_ifetch_err)
        |=> (ctx_vpn == badvaddr[XLEN-1:VPN_LO] && ehi_vpn == badvaddr[XLEN-1:VPN_LO]
             && cause_code == CODE_XLATE))
        else $error("R6 page fields mismatch");

    // R8: breakpoint targets the debug vector
    a_r8_debug_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_dbg_break) |=> (redirect_pc == DBG_VECTOR && dbg_bp))
        else $error("R8 wrong debug vector");

    logic unused_any;
    assign unused_any = any_req;
endmodule

// File: tb/exc_prio_capture_tb.sv
`timescale 1ns/1ps
module exc_prio_capture_tb;
    localparam logic [31:0] BASE   = 32'h8000_0000;
    localparam logic [31:0] DVEC   = 32'hBFC0_0480;
    localparam logic [31:0] GVEC   = BASE + 32'h180;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        req_valid = 0, r_if = 0, r_dd = 0, r_sys = 0, r_dbg = 0, r_xl = 0;
    logic        impr = 0, dslot = 0;
    logic [31:0] ipc = 0, bpc = 0, va = 0;
    logic [7:0]  asid = 0;

    logic        redirect_valid, cause_bd, cause_imprecise, dbg_bp, dbg_dd;
    logic [31:0] redirect_pc, epc, badvaddr, depc;
    logic [4:0]  cause_code;
    logic [18:0] ctx_vpn, ehi_vpn;
    logic [7:0]  ehi_asid;

    exc_prio_capture #(.EXC_BASE(BASE), .DBG_VECTOR(DVEC)) u_dut (
        .clk, .rst_n, .req_valid,
        .req_ifetch_err(r_if), .req_data_err(r_dd), .req_syscall(r_sys),
        .req_dbg_break(r_dbg), .req_xlate_inv(r_xl),
        .err_imprecise(impr), .in_delay_slot(dslot),
        .inst_pc(ipc), .branch_pc(bpc), .fault_vaddr(va), .fault_asid(asid),
        .redirect_valid, .redirect_pc, .cause_code, .cause_bd, .cause_imprecise,
        .epc, .badvaddr, .ctx_vpn, .ehi_vpn, .ehi_asid, .dbg_bp, .dbg_dd, .depc
    );

    typedef struct {
        logic        v;
        logic [31:0] pc;
        logic [4:0]  code;
        logic        bd;
        logic        im;
        logic [31:0] epc;
        logic [31:0] bad;
        logic [18:0] cv;
        logic [18:0] hv;
        logic [7:0]  as;
        logic        bp;
        logic        dd;
        logic [31:0] dpc;
    } exp_t;

    exp_t  model;
    exp_t  exp_q[$];
    string tag_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;

    task automatic field(input string tag, input string nm, input logic [31:0] a,
                         input logic [31:0] e, inout bit bad);
        if (a !== e) begin
            $display("FAIL %s %s: actual %h expected %h", tag, nm, a, e);
            bad = 1;
        end
    endtask

    task automatic compare(input string tag, input exp_t e);
        bit bad = 0;
        field(tag, "redirect_valid", 32'(redirect_valid), 32'(e.v), bad);
        field(tag, "redirect_pc", redirect_pc, e.pc, bad);
        field(tag, "cause_code", 32'(cause_code), 32'(e.code), bad);
        field(tag, "cause_bd", 32'(cause_bd), 32'(e.bd), bad);
        field(tag, "cause_imprecise", 32'(cause_imprecise), 32'(e.im), bad);
        field(tag, "epc", epc, e.epc, bad);
        field(tag, "badvaddr", badvaddr, e.bad, bad);
        field(tag, "ctx_vpn", 32'(ctx_vpn), 32'(e.cv), bad);
        field(tag, "ehi_vpn", 32'(ehi_vpn), 32'(e.hv), bad);
        field(tag, "ehi_asid", 32'(ehi_asid), 32'(e.as), bad);
        field(tag, "dbg_bp", 32'(dbg_bp), 32'(e.bp), bad);
        field(tag, "dbg_dd", 32'(dbg_dd), 32'(e.dd), bad);
        field(tag, "depc", depc, e.dpc, bad);
        n_cmp++;
        if (bad) n_bad++;
    endtask

    // Driver: order of r is {sys, data, xlate, fetch, debug}
    task automatic drive(input logic v, input logic [4:0] r, input logic ds,
                         input logic [31:0] ip, input logic [31:0] bp,
                         input logic [31:0] fa, input logic [7:0] as,
                         input logic im, input string tag);
        logic [31:0] ret;
        @(negedge clk);
        req_valid = v; r_dbg = r[0]; r_if = r[1]; r_xl = r[2]; r_dd = r[3]; r_sys = r[4];
        dslot = ds; ipc = ip; bpc = bp; va = fa; asid = as; impr = im;
        ret = ds ? bp : ip;
        model.v = 1'b0;
        if (v && r != 5'b0) begin
            model.v = 1'b1;
            if (r[0]) begin
                model.pc = DVEC; model.bp = 1'b1; model.dd = ds; model.dpc = ret;
            end else begin
                model.pc = GVEC; model.epc = ret; model.bd = ds; model.im = 1'b0;
                if (r[1]) begin
                    model.code = 5'd6; model.im = im;
                end else if (r[2]) begin
                    model.code = 5'd2; model.bad = fa;
                    model.cv = fa[31:13]; model.hv = fa[31:13]; model.as = as;
                end else if (r[3]) begin
                    model.code = 5'd7; model.im = im;
                end else begin
                    model.code = 5'd8;
                end
            end
        end
        exp_q.push_back(model);
        tag_q.push_back(tag);
    endtask

    // Monitor: results appear one edge after the inputs are driven
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() != 0) compare(tag_q.pop_front(), exp_q.pop_front());
        end
    end

    initial begin
        #(20 * 50000);
        $display("FAIL watchdog: actual hung expected completion");
        n_cmp++; n_bad++;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model = '{default: '0};
        repeat (3) @(posedge clk);
        #3;
        compare("R10 reset state", model);
        @(negedge clk);
        rst_n = 1'b1;

        drive(0, 5'b00000, 0, 32'h1000, 32'h0FFC, 32'h0, 8'h0, 0, "R1 idle");
        drive(0, 5'b11111, 1, 32'h1004, 32'h1000, 32'hDEAD_B000, 8'h11, 1, "R1 request ignored without valid");
        drive(1, 5'b00010, 0, 32'h2000, 32'h1FFC, 32'h0, 8'h0, 0, "R4 fetch bus error code 6 R2 vector");
        drive(1, 5'b01000, 1, 32'h2104, 32'h2100, 32'h0, 8'h0, 1, "R5 delay slot data error R9 imprecise");
        drive(1, 5'b10000, 0, 32'h2200, 32'h21FC, 32'h0, 8'h0, 1, "R4 syscall code 8 R9 cleared");
        drive(1, 5'b00100, 0, 32'h2300, 32'h22FC, 32'h7654_3ABC, 8'h5A, 0, "R6 translation fault fields");
        drive(1, 5'b01010, 0, 32'h2400, 32'h23FC, 32'h0, 8'h0, 0, "R3 fetch beats data");
        drive(1, 5'b01100, 0, 32'h2500, 32'h24FC, 32'hFFFF_E123, 8'hA5, 1, "R3 translation beats data R9");
        drive(1, 5'b11000, 1, 32'h2604, 32'h2600, 32'h0, 8'h0, 0, "R3 data beats syscall R7 fields kept");
        drive(1, 5'b00110, 0, 32'h2700, 32'h26FC, 32'h1111_1111, 8'h22, 1, "R3 fetch beats translation R7");
        drive(1, 5'b11111, 1, 32'h2804, 32'h2800, 32'h3333_3333, 8'h44, 1, "R8 debug beats all in delay slot");
        drive(1, 5'b00001, 0, 32'h2900, 32'h28FC, 32'h0, 8'h0, 0, "R8 debug plain slot");
        drive(1, 5'b10000, 1, 32'h2A04, 32'h2A00, 32'h0, 8'h0, 0, "R8 normal keeps debug state R5");
        drive(0, 5'b00000, 0, 32'h2B00, 32'h2AFC, 32'h0, 8'h0, 0, "R1 single cycle strobe");
        drive(1, 5'b00100, 1, 32'h2C04, 32'h2C00, 32'h0000_2000, 8'hFF, 0, "R6 low page boundary R5");
        drive(1, 5'b01000, 0, 32'h2D00, 32'h2CFC, 32'h0, 8'h0, 0, "R9 precise data error R1 back to back");
        drive(1, 5'b00010, 0, 32'h2E00, 32'h2DFC, 32'h0, 8'h0, 1, "R9 imprecise fetch error");
        drive(0, 5'b00100, 0, 32'h2F00, 32'h2EFC, 32'h9999_9999, 8'h99, 0, "R1 masked translation fault");
        drive(0, 5'b00000, 0, 32'h0, 32'h0, 32'h0, 8'h0, 0, "R2 redirect pc held");
        repeat (3) @(posedge clk);
        #5;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule